// File: doc/BRIEF.md
# Character-Cell Raster Timing Generator

This block produces the horizontal and vertical timing of a character-based display. It runs on a character clock. A set of timing values, held steady by the surrounding logic, describes the frame: line length, visible width, sync position and width, row count, extra adjust lines, visible rows, vertical sync row, scan lines per row, interlace mode and the start address. From these the block drives horizontal sync, vertical sync, display enable, a linear memory address and the scan-line address within the current character row.

A parameter picks one of two chip flavours. The programmable flavour takes the vertical sync length from the high nibble of the sync-width value. The fixed flavour always gives a 16-line vertical sync. It also suppresses vertical sync when the horizontal sync would run past the line end. When interlace is selected, it reads the visible-row value as half the number of rows shown.

All timing values are sampled live. They are meant to be changed only while reset is held. Every output is registered, so each one reflects the counter state of the previous clock.

Top module: `crtc_timing_top`

## Requirements
- R1: While `rst` is high, every output reads zero after a clock edge: `hsync_o`, `vsync_o`, `de_o`, `ma_o` and `ra_o`.
- R2: The character counter H runs 0,1,…,`reg_htot` and then wraps to 0. Outputs show the counter state one clock later. `de_o` is high when H < `reg_hdisp`, the frame is not in adjust lines, and the row is below the effective visible-row count.
- R3: `hsync_o` is high when `reg_hspos` ≤ H < `reg_hspos` + `reg_syncw[3:0]`. A width of 0 gives no pulse, and the pulse is cut off at the line end.
- R4: The scan line runs 0..`reg_maxsl`. The row advances when the scan line wraps, for rows 0..`reg_vtot`. Then `reg_vadj` adjust lines follow, during which `ra_o` counts 0..`reg_vadj`-1. After that the frame restarts at row 0, scan line 0. Outside adjust, `ra_o` shows the scan line.
- R5: `ma_o` equals the row base plus H, modulo 2^MW. The row base is `reg_start` at reset and at every frame start. It grows by `reg_hdisp` each time a row ends, except the last row.
- R6: With the programmable flavour, vertical sync is loaded at a line start reached by counting, outside adjust, where the row equals `reg_vspos` and the scan line is 0. It lasts `reg_syncw[7:4]` lines, and a nibble of 0 means 16 lines. A new trigger restarts the count.
- R7: With the fixed flavour, vertical sync lasts 16 lines whatever `reg_syncw[7:4]` holds.
- R8: With the fixed flavour, no vertical sync starts while `reg_htot` ≤ `reg_hspos` + `reg_syncw[3:0]`.
- R9: `reg_mode` values 2'b01 and 2'b11 select interlace, and 2'b00 and 2'b10 do not. In the fixed flavour, interlace makes the visible-row count 2×`reg_vdisp`. In every other case the count is `reg_vdisp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_htot | input | HW | Last character index of a line |
| reg_hdisp | input | HW | Visible characters per line, also row address stride |
| reg_hspos | input | HW | Character index where horizontal sync begins |
| reg_syncw | input | 8 | [3:0] horizontal sync width, [7:4] vertical sync lines |
| reg_vtot | input | VW | Last character row index of a frame |
| reg_vadj | input | SW | Extra scan lines after the last row |
| reg_vdisp | input | VW | Visible rows (halved meaning in fixed flavour with interlace) |
| reg_vspos | input | VW | Row where vertical sync begins |
| reg_mode | input | 2 | Interlace mode |
| reg_maxsl | input | SW | Last scan line index within a row |
| reg_start | input | MW | Memory address at frame start |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| ma_o | output | MW | Linear memory address |
| ra_o | output | SW | Scan-line (row) address |

## Verification
The bench builds two copies side by side with the default widths (8-bit horizontal, 7-bit row, 5-bit scan, 14-bit address). One copy uses the programmable flavour and the other the fixed flavour, and both receive the same timing values. This lets one stimulus stream show the difference between them. Programmed vertical sync lengths, including the zero-means-16 case, are compared against the constant 16 lines. Settings where the horizontal sync overruns the line also show vertical sync present in one copy and absent in the other. The interlace codes reveal doubled versus direct visible rows. Random frame shapes with small counts also cover adjust phases, wrap of the address and retriggered vertical sync within a few thousand clocks.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  typedef enum logic {
    VAR_PROG_VS  = 1'b0,
    VAR_FIXED_VS = 1'b1
  } crtc_variant_e;

  localparam int unsigned FIXED_VS_LINES = 16;

  // Vertical sync length in lines for a flavour and programmed nibble.
  function automatic logic [4:0] vs_lines(input crtc_variant_e v, input logic [3:0] nib);
    if (v == VAR_FIXED_VS || nib == 4'd0) return 5'(FIXED_VS_LINES);
    return {1'b0, nib};
  endfunction
endpackage

// File: rtl/crtc_hctr.sv
module crtc_hctr #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] r_htot,
  input  logic [HW-1:0] r_hdisp,
  input  logic [HW-1:0] r_hspos,
  input  logic [3:0]    r_hswid,
  output logic [HW-1:0] h_q,
  output logic          eol,
  output logic          hs_raw,
  output logic          hde,
  output logic          sync_bad
);
  localparam int EW = HW + 1;

  logic [EW-1:0] hs_end;

  assign eol    = (h_q == r_htot);
  assign hs_end = {1'b0, r_hspos} + {{(EW-4){1'b0}}, r_hswid};
  assign hs_raw = (h_q >= r_hspos) && ({1'b0, h_q} < hs_end);
  assign hde    = (h_q < r_hdisp);
  // horizontal sync would not finish inside the line
  assign sync_bad = !({1'b0, r_htot} > hs_end);

  always_ff @(posedge clk) begin
    if (rst)      h_q <= '0;
    else if (eol) h_q <= '0;
    else          h_q <= h_q + 1'b1;
  end

  // R2
  h_step_chk: assert property (@(posedge clk) disable iff (rst)
    !eol |=> (h_q == $past(h_q) + 1'b1));
  // R2
  h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    eol |=> (h_q == '0));
endmodule

// File: rtl/crtc_vctr.sv
module crtc_vctr
  import crtc_pkg::*;
#(
  parameter int            VW      = 7,
  parameter int            SW      = 5,
  parameter crtc_variant_e VARIANT = VAR_PROG_VS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eol,
  input  logic          sync_bad,
  input  logic          ilace_on,
  input  logic [VW-1:0] r_vtot,
  input  logic [SW-1:0] r_vadj,
  input  logic [VW-1:0] r_vdisp,
  input  logic [VW-1:0] r_vspos,
  input  logic [SW-1:0] r_maxsl,
  input  logic [3:0]    r_vswid,
  output logic [SW-1:0] sl_q,
  output logic          vs_active,
  output logic          vde,
  output logic          row_adv,
  output logic          frame_end
);
  localparam bit FIXED = (VARIANT == VAR_FIXED_VS);

  logic [VW-1:0] row_q, row_n;
  logic [SW-1:0] sl_n;
  logic          adj_q, adj_n;
  logic [4:0]    vs_cnt_q;
  logic          sl_last, row_last, adj_last, enter_adj, vs_hit;
  logic [VW:0]   vdisp_eff;

  assign sl_last   = (sl_q == r_maxsl);
  assign row_last  = (row_q == r_vtot);
  assign adj_last  = (({1'b0, sl_q} + 1'b1) == {1'b0, r_vadj});
  assign frame_end = eol && (adj_q ? adj_last : (sl_last && row_last && (r_vadj == '0)));
  assign enter_adj = eol && !adj_q && sl_last && row_last && (r_vadj != '0);
  assign row_adv   = eol && !adj_q && sl_last && !row_last;

  always_comb begin
    sl_n  = sl_q;
    row_n = row_q;
    adj_n = adj_q;
    if (frame_end) begin
      sl_n  = '0;
      row_n = '0;
      adj_n = 1'b0;
    end else if (enter_adj) begin
      sl_n  = '0;
      adj_n = 1'b1;
    end else if (row_adv) begin
      sl_n  = '0;
      row_n = row_q + 1'b1;
    end else if (eol) begin
      sl_n  = sl_q + 1'b1;
    end
  end

  assign vs_hit = eol && !adj_n && (row_n == r_vspos) && (sl_n == '0) &&
                  !(FIXED && sync_bad);

  always_ff @(posedge clk) begin
    if (rst) begin
      sl_q     <= '0;
      row_q    <= '0;
      adj_q    <= 1'b0;
      vs_cnt_q <= '0;
    end else begin
      sl_q  <= sl_n;
      row_q <= row_n;
      adj_q <= adj_n;
      if (vs_hit)
        vs_cnt_q <= vs_lines(VARIANT, r_vswid);
      else if (eol && vs_cnt_q != '0)
        vs_cnt_q <= vs_cnt_q - 1'b1;
    end
  end

  assign vs_active = (vs_cnt_q != '0);
  assign vdisp_eff = (FIXED && ilace_on) ? {r_vdisp, 1'b0} : {1'b0, r_vdisp};
  assign vde       = !adj_q && ({1'b0, row_q} < vdisp_eff);

  // R6
  vs_bound_chk: assert property (@(posedge clk) disable iff (rst)
    vs_cnt_q <= 5'd16);
  // R8
  vs_suppress_chk: assert property (@(posedge clk) disable iff (rst)
    (FIXED && sync_bad && vs_cnt_q == '0) |=> (vs_cnt_q == '0));
  // R4
  adj_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (adj_q && !eol) |=> (adj_q && $stable(sl_q)));
endmodule

// File: rtl/crtc_maddr.sv
module crtc_maddr #(
  parameter int MW = 14,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] r_start,
  input  logic [HW-1:0] r_hdisp,
  input  logic          row_adv,
  input  logic          frame_end,
  output logic [MW-1:0] base_q
);
  logic [MW-1:0] stride;
  assign stride = MW'(r_hdisp);

  always_ff @(posedge clk) begin
    if (rst || frame_end) base_q <= r_start;
    else if (row_adv)     base_q <= base_q + stride;
  end

  // R5
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!row_adv && !frame_end) |=> $stable(base_q));
endmodule

// File: rtl/crtc_timing_top.sv
module crtc_timing_top
  import crtc_pkg::*;
#(
  parameter int            HW      = 8,
  parameter int            VW      = 7,
  parameter int            SW      = 5,
  parameter int            MW      = 14,
  parameter crtc_variant_e VARIANT = VAR_PROG_VS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] reg_htot,
  input  logic [HW-1:0] reg_hdisp,
  input  logic [HW-1:0] reg_hspos,
  input  logic [7:0]    reg_syncw,
  input  logic [VW-1:0] reg_vtot,
  input  logic [SW-1:0] reg_vadj,
  input  logic [VW-1:0] reg_vdisp,
  input  logic [VW-1:0] reg_vspos,
  input  logic [1:0]    reg_mode,
  input  logic [SW-1:0] reg_maxsl,
  input  logic [MW-1:0] reg_start,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [MW-1:0] ma_o,
  output logic [SW-1:0] ra_o
);
  logic [HW-1:0] h_q;
  logic          eol, hs_raw, hde, sync_bad;
  logic [SW-1:0] sl_q;
  logic          vs_active, vde, row_adv, frame_end, ilace_on;
  logic [MW-1:0] base_q;

  assign ilace_on = (reg_mode == 2'b01) || (reg_mode == 2'b11);

  crtc_hctr #(.HW(HW)) u_hctr (
    .clk(clk), .rst(rst),
    .r_htot(reg_htot), .r_hdisp(reg_hdisp), .r_hspos(reg_hspos),
    .r_hswid(reg_syncw[3:0]),
    .h_q(h_q), .eol(eol), .hs_raw(hs_raw), .hde(hde), .sync_bad(sync_bad)
  );

  crtc_vctr #(.VW(VW), .SW(SW), .VARIANT(VARIANT)) u_vctr (
    .clk(clk), .rst(rst), .eol(eol), .sync_bad(sync_bad), .ilace_on(ilace_on),
    .r_vtot(reg_vtot), .r_vadj(reg_vadj), .r_vdisp(reg_vdisp),
    .r_vspos(reg_vspos), .r_maxsl(reg_maxsl), .r_vswid(reg_syncw[7:4]),
    .sl_q(sl_q), .vs_active(vs_active), .vde(vde),
    .row_adv(row_adv), .frame_end(frame_end)
  );

  crtc_maddr #(.MW(MW), .HW(HW)) u_maddr (
    .clk(clk), .rst(rst), .r_start(reg_start), .r_hdisp(reg_hdisp),
    .row_adv(row_adv), .frame_end(frame_end), .base_q(base_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      ma_o    <= '0;
      ra_o    <= '0;
    end else begin
      hsync_o <= hs_raw;
      vsync_o <= vs_active;
      de_o    <= hde && vde;
      ma_o    <= base_q + MW'(h_q);
      ra_o    <= sl_q;
    end
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!hsync_o && !vsync_o && !de_o && ma_o == '0 && ra_o == '0));
  // R2
  de_window_chk: assert property (@(posedge clk) disable iff (rst)
    de_o |-> ($past(h_q) < $past(reg_hdisp)));
endmodule

// File: tb/crtc_timing_top_bench.sv
module crtc_timing_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [7:0]  r0, r1, r2, r3;
  logic [6:0]  r4, r6, r7;
  logic [4:0]  r5, r9;
  logic [1:0]  r8;
  logic [13:0] r12;

  logic        hs0, vs0, de0, hs1, vs1, de1;
  logic [13:0] ma0, ma1;
  logic [4:0]  ra0, ra1;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  crtc_timing_top u_crtc_timing_top (
    .clk(clk), .rst(rst), .reg_htot(r0), .reg_hdisp(r1), .reg_hspos(r2),
    .reg_syncw(r3), .reg_vtot(r4), .reg_vadj(r5), .reg_vdisp(r6),
    .reg_vspos(r7), .reg_mode(r8), .reg_maxsl(r9), .reg_start(r12),
    .hsync_o(hs0), .vsync_o(vs0), .de_o(de0), .ma_o(ma0), .ra_o(ra0)
  );

  crtc_timing_top #(.VARIANT(crtc_pkg::VAR_FIXED_VS)) u_crtc_timing_top_fix (
    .clk(clk), .rst(rst), .reg_htot(r0), .reg_hdisp(r1), .reg_hspos(r2),
    .reg_syncw(r3), .reg_vtot(r4), .reg_vadj(r5), .reg_vdisp(r6),
    .reg_vspos(r7), .reg_mode(r8), .reg_maxsl(r9), .reg_start(r12),
    .hsync_o(hs1), .vsync_o(vs1), .de_o(de1), .ma_o(ma1), .ra_o(ra1)
  );

  // reference state per flavour (0 programmable, 1 fixed)
  int mh[2], msl[2], mrow[2], madj[2], mvs[2], mbase[2];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish act=%0d exp<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit sync_bad();
    return !(int'(r0) > int'(r2) + int'(r3[3:0]));
  endfunction

  function automatic bit ilace();
    return (r8 == 2'b01) || (r8 == 2'b11);
  endfunction

  task automatic model_reset();
    for (int v = 0; v < 2; v++) begin
      mh[v] = 0; msl[v] = 0; mrow[v] = 0; madj[v] = 0; mvs[v] = 0;
      mbase[v] = int'(r12);
    end
  endtask

  task automatic check_one(input int v, input logic h, input logic vs,
                           input logic d, input logic [13:0] m, input logic [4:0] ra);
    int vd, len;
    bit eh, ed, fe, sl_last, row_last, hit;
    string vtag, dtag;
    eh = (mh[v] >= int'(r2)) && (mh[v] < int'(r2) + int'(r3[3:0]));
    vd = (v == 1 && ilace()) ? 2 * int'(r6) : int'(r6);
    ed = (mh[v] < int'(r1)) && (madj[v] == 0) && (mrow[v] < vd);
    vtag = (v == 0) ? "R6 vsync" : (sync_bad() ? "R8 vsync" : "R7 vsync");
    dtag = ilace() ? "R9 de" : "R2 de";
    chk("R3 hsync", int'(h), int'(eh));
    chk(vtag, int'(vs), int'(mvs[v] != 0));
    chk(dtag, int'(d), int'(ed));
    chk("R5 ma", int'(m), (mbase[v] + mh[v]) % 16384);
    chk("R4 ra", int'(ra), msl[v]);
    // advance reference state by one clock
    if (mh[v] == int'(r0)) begin
      mh[v] = 0;
      sl_last  = (msl[v] == int'(r9));
      row_last = (mrow[v] == int'(r4));
      fe = (madj[v] != 0) ? (msl[v] + 1 == int'(r5))
                          : (sl_last && row_last && r5 == 0);
      if (fe) begin
        msl[v] = 0; mrow[v] = 0; madj[v] = 0; mbase[v] = int'(r12);
      end else if (madj[v] == 0 && sl_last && row_last) begin
        madj[v] = 1; msl[v] = 0;
      end else if (madj[v] == 0 && sl_last) begin
        msl[v] = 0; mrow[v] = mrow[v] + 1;
        mbase[v] = (mbase[v] + int'(r1)) % 16384;
      end else begin
        msl[v] = msl[v] + 1;
      end
      hit = (madj[v] == 0) && (mrow[v] == int'(r7)) && (msl[v] == 0) &&
            !(v == 1 && sync_bad());
      len = (v == 1 || r3[7:4] == 4'd0) ? 16 : int'(r3[7:4]);
      if (hit) mvs[v] = len;
      else if (mvs[v] > 0) mvs[v] = mvs[v] - 1;
    end else begin
      mh[v] = mh[v] + 1;
    end
  endtask

  task automatic run_cfg(input int ncyc);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 outputs quiet under reset
    chk("R1 reset hs", int'(hs0 | hs1), 0);
    chk("R1 reset vs", int'(vs0 | vs1), 0);
    chk("R1 reset de", int'(de0 | de1), 0);
    chk("R1 reset ma", int'(ma0 | ma1), 0);
    chk("R1 reset ra", int'(ra0 | ra1), 0);
    model_reset();
    rst = 1'b0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      check_one(0, hs0, vs0, de0, ma0, ra0);
      check_one(1, hs1, vs1, de1, ma1, ra1);
    end
  endtask

  task automatic set_cfg(input int h0, h1, h2, h3, v4, v5, v6, v7, m8, s9, st);
    r0 = 8'(h0); r1 = 8'(h1); r2 = 8'(h2); r3 = 8'(h3);
    r4 = 7'(v4); r5 = 5'(v5); r6 = 7'(v6); r7 = 7'(v7);
    r8 = 2'(m8); r9 = 5'(s9); r12 = 14'(st);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    // directed: 8-line programmed vsync, adjust lines (R6, R7, R4, R5)
    set_cfg(15, 10, 11, 8'h83, 5, 2, 4, 3, 0, 3, 14'h100);
    run_cfg(1200);
    // directed: hsync overruns line end, fixed flavour drops vsync (R8, R3)
    set_cfg(15, 10, 13, 8'h43, 4, 1, 3, 2, 0, 2, 14'h3ff0);
    run_cfg(900);
    // directed: interlace 01 doubles visible rows in fixed flavour (R9)
    set_cfg(11, 8, 9, 8'h22, 6, 0, 2, 5, 1, 1, 0);
    run_cfg(900);
    // directed: mode 10 is not interlace (R9)
    set_cfg(11, 8, 9, 8'h22, 6, 0, 2, 5, 2, 1, 0);
    run_cfg(700);
    // directed: zero vsync nibble means 16 lines, vsync at row 0 (R6)
    set_cfg(7, 5, 5, 8'h02, 9, 0, 6, 0, 3, 1, 14'h20);
    run_cfg(900);
    // directed: zero hsync width gives no pulse (R3)
    set_cfg(9, 12, 3, 8'h50, 2, 3, 9, 1, 0, 0, 14'h3ffe);
    run_cfg(500);
    for (int k = 0; k < 10; k++) begin
      int a0;
      a0 = 4 + int'($urandom_range(36));
      set_cfg(a0, int'($urandom_range(a0 + 2)), int'($urandom_range(a0 + 1)),
              int'($urandom_range(255)), 1 + int'($urandom_range(11)),
              int'($urandom_range(7)), int'($urandom_range(14)),
              int'($urandom_range(13)), int'($urandom_range(3)),
              int'($urandom_range(7)), int'($urandom_range(16383)));
      run_cfg(3000);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule